// File: doc/BRIEF.md
# Fractional Baud Generator

This block derives the 16x oversampling strobe of a serial receiver or transmitter from a reference clock, with a resolution of one sixteenth of a sample period. The required division ratio is the reference rate over the baud rate. Its upper part, divided by sixteen and less one, goes into the divisor register. Its low four bits choose how many of the sixteen sample slots in a bit period get one extra reference clock. A 16-bit slot mask marks those slots. Masks whose set bits are spread evenly, such as 0x4924 for five extra clocks or 0xD5D5 for ten, keep the jitter of each sample point within one reference clock.

Software writes the divisor and the mask through a small register port and may read both back. New values are held in a staging copy and go live only at a bit-period boundary, so a slot is never cut short or stretched mid-way. The outputs are a sample tick at the end of each slot and a bit strobe that coincides with every sixteenth tick.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `tick_o` and `bit_o` are low after that edge, and the slot index and clock counter return to zero.
- R2: A write with `wr_en` high and `wr_sel` = 0 stores `wr_data[DIV_W-1:0]` as the divisor and ignores the upper data bits. With `wr_sel` = 1 it stores all 16 bits as the slot mask. `rd_data` shows the divisor (zero-extended) when `rd_sel` = 0 and the mask when `rd_sel` = 1, combinationally.
- R3: Slot k lasts divisor+1 reference clocks, plus one more when mask bit k is set. Slot 0 is the first slot after a bit strobe or after reset. `tick_o` is high for the one clock following the last clock of each slot.
- R4: `bit_o` is high together with the tick that ends slot 15 and at no other time.
- R5: One bit period, measured from one bit strobe to the next, spans 16*(divisor+1) + popcount(mask) reference clocks.
- R6: A divisor or mask written during a bit period has no effect on the remaining slots of that period. It governs every slot from the next period on.
- R7: Reset leaves the programmed divisor and mask unchanged and loads them into the live copy. The first tick after reset is released therefore comes divisor+1+mask[0] clocks after the first clock edge with `rst` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 divisor, 1 slot mask |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Readback select: 0 divisor, 1 slot mask |
| rd_data | output | 16 | Readback data |
| tick_o | output | 1 | Oversample tick, one clock wide, at the end of each slot |
| bit_o | output | 1 | Bit-period strobe, coincides with every 16th tick |

## Verification
A wrong slot index or counter shows up at the very next tick: the gap between ticks no longer matches divisor+1 plus the mask bit of that slot. A stale or early-loaded live divisor or mask is seen within one bit period: the strobe spacing departs from 16*(divisor+1)+popcount(mask), or it departs in the period that follows a write. Measuring every tick gap against a slot-by-slot model therefore catches a fault within one slot of its cause.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    // number of oversample slots in one bit period and width of the slot index
    localparam int SLOTS  = 16;
    localparam int SLOT_W = $clog2(SLOTS);
    // data port width equals the slot mask width
    localparam int DATA_W = SLOTS;

    typedef enum logic {
        SEL_DIV  = 1'b0,
        SEL_MASK = 1'b1
    } fbg_sel_e;
endpackage

// File: rtl/fbg_cfg_regs.sv
// Software-visible staging registers for divisor and slot mask.
module fbg_cfg_regs
    import fbg_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [DIV_W-1:0]  div_o,
    output logic [SLOTS-1:0]  mask_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [SLOTS-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (fbg_sel_e'(wr_sel) == SEL_DIV) cfg_d.div  = wr_data[DIV_W-1:0];
            else                               cfg_d.mask = wr_data[SLOTS-1:0];
        end
    end

    // deliberately not reset: programmed values survive a counter reset
    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign rd_data = (fbg_sel_e'(rd_sel) == SEL_MASK) ? DATA_W'(cfg_q.mask)
                                                      : DATA_W'(cfg_q.div);
    assign div_o   = cfg_q.div;
    assign mask_o  = cfg_q.mask;
endmodule

// File: rtl/fbg_slot_timer.sv
// Counts reference clocks per slot, walks the slot index, and reloads the
// live divisor and mask at each bit-period boundary.
module fbg_slot_timer
    import fbg_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [SLOTS-1:0]  mask_i,
    output logic              tick_o,
    output logic              bit_o,
    output logic [DIV_W-1:0]  act_div_o,
    output logic [SLOTS-1:0]  act_mask_o,
    output logic [SLOT_W-1:0] slot_o
);
    localparam int CNT_W = DIV_W + 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [SLOT_W-1:0] idx;
        logic [DIV_W-1:0]  act_div;
        logic [SLOTS-1:0]  act_mask;
        logic              tick;
        logic              bitp;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [CNT_W-1:0] last_d;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        st_d.bitp = 1'b0;
        // final count of the running slot: divisor, plus one if stretched
        last_d = CNT_W'(st_q.act_div) + CNT_W'(st_q.act_mask[st_q.idx]);
        if (st_q.cnt == last_d) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
            st_d.idx  = st_q.idx + 1'b1;
            if (st_q.idx == LAST_SLOT) begin
                st_d.bitp     = 1'b1;
                st_d.act_div  = div_i;
                st_d.act_mask = mask_i;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (rst) begin
            st_d.cnt      = '0;
            st_d.idx      = '0;
            st_d.tick     = 1'b0;
            st_d.bitp     = 1'b0;
            st_d.act_div  = div_i;
            st_d.act_mask = mask_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign tick_o     = st_q.tick;
    assign bit_o      = st_q.bitp;
    assign act_div_o  = st_q.act_div;
    assign act_mask_o = st_q.act_mask;
    assign slot_o     = st_q.idx;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [15:0] wr_data,
    input  logic        rd_sel,
    output logic [15:0] rd_data,
    output logic        tick_o,
    output logic        bit_o
);
    logic [DIV_W-1:0]  stg_div;
    logic [SLOTS-1:0]  stg_mask;
    logic [DIV_W-1:0]  act_div;
    logic [SLOTS-1:0]  act_mask;
    logic [SLOT_W-1:0] slot_idx;

    fbg_cfg_regs #(.DIV_W(DIV_W)) u_regs (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .rd_sel (rd_sel),
        .rd_data(rd_data),
        .div_o  (stg_div),
        .mask_o (stg_mask)
    );

    fbg_slot_timer #(.DIV_W(DIV_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .div_i     (stg_div),
        .mask_i    (stg_mask),
        .tick_o    (tick_o),
        .bit_o     (bit_o),
        .act_div_o (act_div),
        .act_mask_o(act_mask),
        .slot_o    (slot_idx)
    );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker
    import fbg_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              bit_p,
    input logic [DIV_W-1:0]  act_div,
    input logic [SLOTS-1:0]  act_mask,
    input logic [SLOT_W-1:0] slot_idx
);
    localparam int GAP_W = DIV_W + 2;

    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] slot_len;

    // clocks elapsed since the previous tick (or since reset)
    always_ff @(posedge clk) begin
        if (rst)       gap_q <= '0;
        else if (tick) gap_q <= GAP_W'(1);
        else           gap_q <= gap_q + 1'b1;
    end

    assign slot_len = GAP_W'(act_div) + GAP_W'(1) + GAP_W'(act_mask[slot_idx]);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!tick && !bit_p)); // R1

    AST_SLOT_LEN: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap_q == $past(slot_len))); // R3

    AST_BIT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        bit_p |-> tick); // R4

    AST_BIT_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        bit_p |-> (slot_idx == '0)); // R4

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$stable(act_div) || !$stable(act_mask)) |-> bit_p); // R6
endmodule

bind frac_baud_gen fbg_checker #(.DIV_W(DIV_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_o),
    .bit_p   (bit_o),
    .act_div (act_div),
    .act_mask(act_mask),
    .slot_idx(slot_idx)
);

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;
    localparam int DIV_W = 12;
    localparam int NVEC  = 8;
    // {divisor[11:0], mask[15:0]}
    localparam logic [27:0] VEC [NVEC] = '{
        {12'd3, 16'h0000}, {12'd3, 16'h0080}, {12'd2, 16'h0808},
        {12'd4, 16'h2222}, {12'd2, 16'h4924}, {12'd5, 16'hD5D5},
        {12'd1, 16'hFFDF}, {12'd0, 16'hFFFF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [15:0] rd_data;
    logic        tick_o, bit_o;

    frac_baud_gen #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .tick_o(tick_o), .bit_o(bit_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    // model state
    int          k = 0, gap = 0, period = 0, bits_seen = 0;
    int          cur_div = 0, pend_div = 0;
    logic [15:0] cur_mask = '0, pend_mask = '0;
    bit          changed = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-level monitor, samples on falling edges
    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                chk(!tick_o && !bit_o, "R1", int'({tick_o, bit_o}), 0);
                gap = 0; k = 0; period = 0; changed = 0;
                cur_div = pend_div; cur_mask = pend_mask;
            end else begin
                gap++; period++;
                if (tick_o) begin
                    chk(gap == cur_div + 1 + int'(cur_mask[k]), "R3", gap,
                        cur_div + 1 + int'(cur_mask[k]));
                    chk(bit_o == (k == 15), "R4", int'(bit_o), int'(k == 15));
                    gap = 0;
                    if (k == 15) begin
                        chk(period == 16 * (cur_div + 1) + $countones(cur_mask),
                            changed ? "R6" : "R5", period,
                            16 * (cur_div + 1) + $countones(cur_mask));
                        changed = (cur_div != pend_div) || (cur_mask != pend_mask);
                        cur_div = pend_div; cur_mask = pend_mask;
                        period = 0; k = 0; bits_seen++;
                    end else begin
                        k++;
                    end
                end else if (bit_o) begin
                    chk(1'b0, "R4", 1, 0);
                end
            end
        end
    end

    task automatic write_reg(input bit sel, input logic [15:0] data);
        forever begin
            @(negedge clk); #1;
            if (rst || k <= 13) break;
        end
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        if (sel) pend_mask = data;
        else     pend_div  = int'(data[DIV_W-1:0]);
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic check_rd(input bit sel, input logic [15:0] exp);
        rd_sel = sel; #1;
        chk(rd_data == exp, "R2", int'(rd_data), int'(exp));
    endtask

    task automatic wait_bits(input int n);
        int target;
        target = bits_seen + n;
        while (bits_seen < target) @(negedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            errs++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int n;
        // reset with smallest configuration
        write_reg(1'b0, 16'h0000);
        write_reg(1'b1, 16'h0000);
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        wait_bits(2);

        // R2: upper divisor data bits ignored, readback zero-extended
        write_reg(1'b0, 16'hF003);
        check_rd(1'b0, 16'h0003);
        wait_bits(2);

        // vector table: program, read back, let monitor verify R3..R6
        for (int i = 0; i < NVEC; i++) begin
            write_reg(1'b0, {4'h0, VEC[i][27:16]});
            write_reg(1'b1, VEC[i][15:0]);
            check_rd(1'b0, {4'h0, VEC[i][27:16]});
            check_rd(1'b1, VEC[i][15:0]);
            wait_bits(3);
        end

        // R7: reset keeps programmed registers
        @(negedge clk); #1 rst = 1'b1;
        repeat (2) @(negedge clk); #1;
        check_rd(1'b0, 16'h0000);
        check_rd(1'b1, 16'hFFFF);
        // reprogram during reset, then release: first tick after 4+1+1 clocks
        write_reg(1'b0, 16'd4);
        write_reg(1'b1, 16'h0001);
        repeat (2) @(negedge clk);
        #1 rst = 1'b0;
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!tick_o && n < 100);
        chk(n == 6, "R7", n, 6);
        wait_bits(2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule